// File: doc/BRIEF.md
# Configurable Gated Registered Buffer

This block is the register stage on a memory-module command and address path. A set of data inputs is captured on every rising clock edge and driven out on registered outputs. Two static configuration inputs choose how the inputs reach the outputs. In the wide mode every input drives one output. In the narrow mode a subset of the inputs is used, and each drives an identical pair of outputs: an A copy and a B copy. The narrow mode has two source selections: the low group of inputs or the high group.

Two chip-select inputs control a hold on the general data outputs. When both are high at a clock edge, those outputs keep their value. The dedicated chip-select, on-die-termination and clock-enable outputs are never held. Tying the auxiliary select low turns the hold off for good. An asynchronous active-low reset clears every output at once and takes priority over the hold.

Top module: `gated_reg_buffer`

## Requirements
- R1: Wide mode (`fanout_i`=0, `bank_i`=0): on each loading edge, `q_a_o` takes all `WIDE_W` bits of `data_i` bit for bit, and `q_b_o` is 0.
- R2: Narrow low mode (`fanout_i`=1, `bank_i`=0): on each loading edge, `q_a_o[NARROW_W-1:0]` and `q_b_o` both take `data_i[NARROW_W-1:0]`. `q_a_o[WIDE_W-1:NARROW_W]` is 0, and the other input bits have no effect.
- R3: Narrow high mode (`fanout_i`=1, `bank_i`=1): on each loading edge, `q_a_o[NARROW_W-1:0]` and `q_b_o` both take `data_i[WIDE_W-1:WIDE_W-NARROW_W]`. `q_a_o[WIDE_W-1:NARROW_W]` is 0, and the other input bits have no effect.
- R4: The illegal setting `fanout_i`=0 with `bank_i`=1 behaves exactly as the wide mode of R1.
- R5: When `cs_i` and `cs_hold_i` are both 1 at a rising edge, `q_a_o` and `q_b_o` keep their previous values, even if `data_i` or the configuration changes.
- R6: When `cs_i` or `cs_hold_i` is 0 at a rising edge, the edge is a loading edge: `q_a_o` and `q_b_o` take the newly mapped data.
- R7: `cs_o`, `odt_o` and `cke_o` take the values of `cs_i`, `odt_i` and `cke_i` on every rising edge, whatever the hold state.
- R8: While `rst_ni` is 0, every output is 0. This takes effect at once, with no clock edge needed.
- R9: After `rst_ni` rises, every output stays 0 until the next rising clock edge. That edge loads normally.
- R10: With `cs_hold_i` held at 0, the general outputs follow the data on every edge, whatever `cs_i` does.
- R11: A change of `fanout_i` or `bank_i` takes effect at the first rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fanout_i | input | 1 | 0: one-to-one mapping, 1: one-to-two mapping |
| bank_i | input | 1 | Source group select in the one-to-two mapping |
| cs_i | input | 1 | Chip select; also drives `cs_o` |
| cs_hold_i | input | 1 | Auxiliary select; a hold needs this and `cs_i` both high |
| odt_i | input | 1 | On-die-termination control input |
| cke_i | input | 1 | Clock-enable control input |
| data_i | input | WIDE_W | General data inputs |
| q_a_o | output | WIDE_W | General outputs, A copy (all bits in wide mode) |
| q_b_o | output | NARROW_W | General outputs, B copy (narrow modes only) |
| cs_o | output | 1 | Registered chip select, never held |
| odt_o | output | 1 | Registered termination control, never held |
| cke_o | output | 1 | Registered clock enable, never held |

## Verification
The hardest case to reach is a hold that spans a configuration change. There the registered outputs must keep a value that the new mapping would never produce, while the control outputs keep updating. The stimulus switches modes during runs of held edges and then releases the hold, so the first loading edge must apply the new mapping. A reset is also asserted and released in the middle of a clock period. The outputs are sampled between the two clock edges, to confirm that they clear at once and stay clear until the next edge.

// File: rtl/gbuf_pkg.sv
package gbuf_pkg;
  typedef enum logic [1:0] {
    MAP_WIDE      = 2'd0,
    MAP_NARROW_LO = 2'd1,
    MAP_NARROW_HI = 2'd2
  } map_e;
endpackage

// File: rtl/gbuf_mode_dec.sv
module gbuf_mode_dec
  import gbuf_pkg::*;
(
  input  logic fanout_i,
  input  logic bank_i,
  output map_e mode_o
);
  // bank is only meaningful in the one-to-two mapping; illegal combo folds to wide
  always_comb begin
    if (!fanout_i)   mode_o = MAP_WIDE;
    else if (bank_i) mode_o = MAP_NARROW_HI;
    else             mode_o = MAP_NARROW_LO;
  end
endmodule

// File: rtl/gbuf_fanout.sv
module gbuf_fanout
  import gbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  map_e                mode_i,
  input  logic [WIDE_W-1:0]   data_i,
  output logic [WIDE_W-1:0]   next_a_o,
  output logic [NARROW_W-1:0] next_b_o
);
  localparam int HI_OFS = WIDE_W - NARROW_W;

  logic [NARROW_W-1:0] src_lo;
  logic [NARROW_W-1:0] src_hi;

  assign src_lo = data_i[NARROW_W-1:0];
  assign src_hi = data_i[WIDE_W-1:HI_OFS];

  always_comb begin
    next_a_o = '0;
    next_b_o = '0;
    unique case (mode_i)
      MAP_NARROW_LO: begin
        next_a_o[NARROW_W-1:0] = src_lo;
        next_b_o               = src_lo;
      end
      MAP_NARROW_HI: begin
        next_a_o[NARROW_W-1:0] = src_hi;
        next_b_o               = src_hi;
      end
      default: next_a_o = data_i;
    endcase
  end
endmodule

// File: rtl/gbuf_regs.sv
module gbuf_regs #(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hold_i,
  input  logic [WIDE_W-1:0]   next_a_i,
  input  logic [NARROW_W-1:0] next_b_i,
  input  logic                cs_i,
  input  logic                odt_i,
  input  logic                cke_i,
  output logic [WIDE_W-1:0]   q_a_o,
  output logic [NARROW_W-1:0] q_b_o,
  output logic                cs_o,
  output logic                odt_o,
  output logic                cke_o
);
  // general outputs: gated by hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_a_o <= '0;
      q_b_o <= '0;
    end else if (!hold_i) begin
      q_a_o <= next_a_i;
      q_b_o <= next_b_i;
    end
  end

  // control outputs: never gated
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_o  <= 1'b0;
      odt_o <= 1'b0;
      cke_o <= 1'b0;
    end else begin
      cs_o  <= cs_i;
      odt_o <= odt_i;
      cke_o <= cke_i;
    end
  end
endmodule

// File: rtl/gated_reg_buffer.sv
module gated_reg_buffer
  import gbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fanout_i,
  input  logic                bank_i,
  input  logic                cs_i,
  input  logic                cs_hold_i,
  input  logic                odt_i,
  input  logic                cke_i,
  input  logic [WIDE_W-1:0]   data_i,
  output logic [WIDE_W-1:0]   q_a_o,
  output logic [NARROW_W-1:0] q_b_o,
  output logic                cs_o,
  output logic                odt_o,
  output logic                cke_o
);
  map_e                mode;
  logic [WIDE_W-1:0]   next_a;
  logic [NARROW_W-1:0] next_b;
  logic                hold;

  assign hold = cs_i & cs_hold_i;

  gbuf_mode_dec i_mode_dec (
    .fanout_i (fanout_i),
    .bank_i   (bank_i),
    .mode_o   (mode)
  );

  gbuf_fanout #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
  ) i_fanout (
    .mode_i   (mode),
    .data_i   (data_i),
    .next_a_o (next_a),
    .next_b_o (next_b)
  );

  gbuf_regs #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (hold),
    .next_a_i (next_a),
    .next_b_i (next_b),
    .cs_i     (cs_i),
    .odt_i    (odt_i),
    .cke_i    (cke_i),
    .q_a_o    (q_a_o),
    .q_b_o    (q_b_o),
    .cs_o     (cs_o),
    .odt_o    (odt_o),
    .cke_o    (cke_o)
  );
endmodule

// File: rtl/gbuf_checker.sv
module gbuf_checker #(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                fanout_i,
  input logic                bank_i,
  input logic                cs_i,
  input logic                cs_hold_i,
  input logic                odt_i,
  input logic                cke_i,
  input logic [WIDE_W-1:0]   data_i,
  input logic [WIDE_W-1:0]   q_a_o,
  input logic [NARROW_W-1:0] q_b_o,
  input logic                cs_o,
  input logic                odt_o,
  input logic                cke_o
);
  localparam int HI_OFS = WIDE_W - NARROW_W;

  // R1 and R4: bank is ignored when fanout is low
  a_r1_wide_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fanout_i && !(cs_i && cs_hold_i)) |=> (q_a_o == $past(data_i) && q_b_o == '0));

  a_r2_narrow_dup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fanout_i && !(cs_i && cs_hold_i)) |=>
      (q_a_o[NARROW_W-1:0] == q_b_o && q_a_o[WIDE_W-1:NARROW_W] == '0));

  a_r3_hi_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fanout_i && bank_i && !(cs_i && cs_hold_i)) |=> (q_b_o == $past(data_i[WIDE_W-1:HI_OFS])));

  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && cs_hold_i) |=> ($stable(q_a_o) && $stable(q_b_o)));

  a_r7_ctrl_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (cs_o == $past(cs_i) && odt_o == $past(odt_i) && cke_o == $past(cke_i)));

  a_r8_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (q_a_o == '0 && q_b_o == '0 && !cs_o && !odt_o && !cke_o));
endmodule

bind gated_reg_buffer gbuf_checker #(
  .WIDE_W   (WIDE_W),
  .NARROW_W (NARROW_W)
) i_gbuf_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fanout_i  (fanout_i),
  .bank_i    (bank_i),
  .cs_i      (cs_i),
  .cs_hold_i (cs_hold_i),
  .odt_i     (odt_i),
  .cke_i     (cke_i),
  .data_i    (data_i),
  .q_a_o     (q_a_o),
  .q_b_o     (q_b_o),
  .cs_o      (cs_o),
  .odt_o     (odt_o),
  .cke_o     (cke_o)
);

// File: tb/test_gated_reg_buffer.sv
`timescale 1ns/1ps
module test_gated_reg_buffer;
  localparam int WIDE_W   = 25;
  localparam int NARROW_W = 14;
  localparam int HI_OFS   = WIDE_W - NARROW_W;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                fanout = 1'b0, bank = 1'b0, cs = 1'b0, cs_hold = 1'b0, odt = 1'b0, cke = 1'b0;
  logic [WIDE_W-1:0]   data = '0;
  logic [WIDE_W-1:0]   q_a;
  logic [NARROW_W-1:0] q_b;
  logic                cs_q, odt_q, cke_q;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 0;
  string tag = "R8";

  always #4 clk = ~clk;

  gated_reg_buffer #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) i_gated_reg_buffer (
    .clk_i(clk), .rst_ni(rst_n), .fanout_i(fanout), .bank_i(bank), .cs_i(cs),
    .cs_hold_i(cs_hold), .odt_i(odt), .cke_i(cke), .data_i(data),
    .q_a_o(q_a), .q_b_o(q_b), .cs_o(cs_q), .odt_o(odt_q), .cke_o(cke_q)
  );

  // behavioural reference: packed integers per output group
  logic [WIDE_W-1:0]   m_a = '0;
  logic [NARROW_W-1:0] m_b = '0;
  logic [2:0]          m_ctl = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = '0; m_b = '0; m_ctl = '0;
    end else begin
      m_ctl = {cs, odt, cke};
      if (!(cs && cs_hold)) begin
        m_a = '0; m_b = '0;
        if (fanout) begin
          for (int i = 0; i < NARROW_W; i++) begin
            m_a[i] = bank ? data[HI_OFS + i] : data[i];
            m_b[i] = m_a[i];
          end
        end else begin
          m_a = data;
        end
      end
    end
  end

  task automatic check_all(string req);
    n_checks++;
    if (q_a !== m_a || q_b !== m_b || {cs_q, odt_q, cke_q} !== m_ctl) begin
      n_errors++;
      $display("FAIL %s t=%0t actual a=%h b=%h ctl=%b expected a=%h b=%h ctl=%b",
               req, $time, q_a, q_b, {cs_q, odt_q, cke_q}, m_a, m_b, m_ctl);
    end
  endtask

  task automatic check_zero(string req);
    n_checks++;
    if (q_a !== '0 || q_b !== '0 || {cs_q, odt_q, cke_q} !== 3'b000) begin
      n_errors++;
      $display("FAIL %s t=%0t actual a=%h b=%h ctl=%b expected all zero",
               req, $time, q_a, q_b, {cs_q, odt_q, cke_q});
    end
  endtask

  // hmode 0: cs_hold low, 1: random selects, 2: always hold
  task automatic run(int n, bit fo, bit bk, int hmode, string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_all(tag);
      tag     = req;
      fanout  = fo;
      bank    = bk;
      data    = WIDE_W'($urandom);
      odt     = 1'($urandom);
      cke     = 1'($urandom);
      cs      = (hmode == 2) ? 1'b1 : 1'($urandom);
      cs_hold = (hmode == 0) ? 1'b0 : (hmode == 2) ? 1'b1 : 1'($urandom);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #2;
    check_zero("R8");                  // reset from time zero
    @(negedge clk); check_zero("R8");
    #2 rst_n = 1'b1;                   // release mid-period
    #1 check_zero("R9");
    tag = "R9";
    run(1, 1'b0, 1'b0, 0, "R9");       // first edge after release loads
    run(20, 1'b0, 1'b0, 0, "R1");
    run(20, 1'b1, 1'b0, 0, "R2");
    run(20, 1'b1, 1'b1, 0, "R3");
    run(20, 1'b0, 1'b1, 0, "R4");
    run(30, 1'b0, 1'b0, 0, "R10");
    run(4, 1'b1, 1'b1, 0, "R11");
    run(6, 1'b1, 1'b1, 2, "R5");       // hold, then switch mode while held
    run(6, 1'b0, 1'b0, 2, "R5");
    run(4, 1'b0, 1'b0, 2, "R7");
    run(2, 1'b1, 1'b0, 0, "R11");      // release hold into a new mapping
    run(2, 1'b0, 1'b0, 0, "R11");
    run(40, 1'b1, 1'b0, 1, "R6");
    run(40, 1'b0, 1'b1, 1, "R6");
    run(10, 1'b1, 1'b1, 1, "R7");
    @(negedge clk); check_all(tag);
    #1 rst_n = 1'b0;                   // async reset mid-period
    #1 check_zero("R8");
    @(negedge clk); check_zero("R8");
    #1 rst_n = 1'b1;
    #1 check_zero("R9");
    tag = "R9";
    run(10, 1'b1, 1'b0, 1, "R2");
    @(negedge clk); check_all(tag);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule